// File: doc/BRIEF.md
# Two-wire EEPROM transaction sequencer

This block turns one memory-style request into the ordered list of bit-engine commands that a serial two-wire EEPROM or register device expects. It sits above a separate engine that produces START, STOP, byte-write and byte-read conditions on the bus. A request carries an operation (probe, write or read), a 7-bit device address, an internal address of zero to `ADDR_BYTES` bytes, a byte count, and an optional mask. The mask folds high internal-address bits into the device address, for small parts that hide address bits in the device-select field.

Write payload arrives on a byte stream with valid/ready, and read payload leaves on a byte stream with valid/ready. The sequencer waits between engine commands while either stream holds it back. The sequencer has no repeated-start condition: between the addressing phase and the read phase it issues a full STOP, then a fresh START. When the transaction ends, a one-cycle response reports an error flag and the number of write-data bytes the device refused.

Top module: `memxfer_seq`

## Requirements
- R1: The byte written right after a START is the device address in bits 7:1 with a direction bit in bit 0, 0 for the write-direction phase and 1 for the read phase. Engine command codes are 0 START, 1 STOP, 2 WRITE, 3 READ. Request operation codes are 0 probe, 1 write, 2 or 3 read.
- R2: A probe issues START, WRITE of the write-direction device address, then STOP. `resp_err` is 0 when that byte was acknowledged and 1 when it was refused.
- R3: The internal address is written as `req_alen` bytes, most significant first, taken from the low bytes of `req_addr`. A length above `ADDR_BYTES` is treated as `ADDR_BYTES`.
- R4: A read with a nonzero address length first runs the write-direction addressing phase. It then issues STOP, then START, then the read-direction device address.
- R5: A read with a zero address length sends the read-direction device address directly after the first START.
- R6: Each READ command carries an acknowledge flag of 0, except the last byte of the count, which carries 1; a STOP follows. Read bytes appear on `rd_data` in order and stay unchanged while `rd_valid` is high and `rd_ready` is low.
- R7: If the device address is refused in the write-direction phase, the block issues STOP and ends with `resp_err`=1, with no further bytes.
- R8: If an internal-address byte is refused, the block ends with `resp_err`=1 and issues no further command, not even a STOP.
- R9: A refused write-data byte does not stop the transfer. All bytes are written, then STOP, and `resp_fails` equals the number of refused data bytes.
- R10: With `req_fold_en`=1, the internal-address bits above the given length are ANDed with `req_fold_mask` and ORed into the device address. The address length is unchanged. With `req_fold_en`=0 the device address is used as given.
- R11: A byte count of zero runs only the addressing phases, then STOP: after the internal address for a write, and after the read-direction device address for a read.
- R12: After reset only `req_ready` is asserted. An engine command stays stable while `eng_cmd_valid` is high and `eng_cmd_ready` is low. The next command is issued only after `eng_done` for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted on valid |
| req_op | input | 2 | 0 probe, 1 write, 2/3 read |
| req_dev | input | 7 | Device address |
| req_addr | input | 8*ADDR_BYTES | Internal address |
| req_alen | input | ALEN_W | Internal address length in bytes |
| req_count | input | CNT_W | Payload byte count |
| req_fold_en | input | 1 | Fold high address bits into device address |
| req_fold_mask | input | 7 | Device-address bits that may receive folded bits |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| eng_cmd_valid | output | 1 | Engine command offered |
| eng_cmd_ready | input | 1 | Engine takes the command |
| eng_cmd_op | output | 2 | Engine command code |
| eng_cmd_byte | output | 8 | Byte for a WRITE command |
| eng_cmd_nack | output | 1 | Acknowledge level to drive after a READ |
| eng_done | input | 1 | Engine finished the command (one cycle) |
| eng_rx_byte | input | 8 | Byte returned by a READ |
| eng_rx_nack | input | 1 | Device refused the byte of a WRITE |
| resp_valid | output | 1 | Transaction finished (one cycle) |
| resp_err | output | 1 | Transaction aborted or probe found no device |
| resp_fails | output | CNT_W | Refused write-data bytes |

## Verification
On the final byte of a write, the refusal counter and the launch of the closing STOP both act on the same engine completion. A directed write forces the device model to refuse exactly that last byte. The response must then show one failure and the command log must end in a STOP. Each byte handoff on the read stream also launches the next READ or STOP in the same cycle. The bench holds `rd_ready` low for varying spans and compares both the delivered bytes and the acknowledge flag of every logged READ.

// File: rtl/memxfer_pkg.sv
package memxfer_pkg;

  localparam int DEV_W = 7;

  typedef enum logic [1:0] {
    ENG_START = 2'd0,
    ENG_STOP  = 2'd1,
    ENG_WRITE = 2'd2,
    ENG_READ  = 2'd3
  } eng_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START1,
    ST_DEVW,
    ST_ADDR,
    ST_STOPM,
    ST_START2,
    ST_DEVR,
    ST_WWAIT,
    ST_WDATA,
    ST_RDATA,
    ST_RPUSH,
    ST_STOPF,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/memxfer_devfold.sv
module memxfer_devfold
  import memxfer_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int ALEN_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DEV_W-1:0]        dev,
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [ALEN_W-1:0]       alen,
  input  logic                    en,
  input  logic [DEV_W-1:0]        mask,
  output logic [DEV_W-1:0]        dev_out
);

  localparam int AW = 8 * ADDR_BYTES;

  logic [AW-1:0] upper;

  // bits above the address length; a length of ADDR_BYTES or more leaves none
  always_comb begin
    upper = '0;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (alen == ALEN_W'(k)) upper = addr >> (8 * k);
    end
  end

  assign dev_out = en ? (dev | (upper[DEV_W-1:0] & mask)) : dev;

  // R10: folding may only set bits that the mask allows
  p_fold_bits_r10: assert property (@(posedge clk) disable iff (rst)
    ((dev_out & ~(dev | mask)) == '0));

endmodule

// File: rtl/memxfer_bytesel.sv
module memxfer_bytesel #(
  parameter int ADDR_BYTES = 4,
  parameter int ALEN_W     = 3
) (
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [ALEN_W-1:0]       idx,
  output logic [7:0]              sel
);

  logic [7:0] lane [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    assign lane[g] = addr[8*g +: 8];
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (idx == ALEN_W'(k)) sel = lane[k];
    end
  end

endmodule

// File: rtl/memxfer_ctrl.sv
module memxfer_ctrl
  import memxfer_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int ALEN_W     = 3,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  input  logic [ALEN_W-1:0]       req_alen,
  input  logic [CNT_W-1:0]        req_count,
  input  logic [DEV_W-1:0]        dev_eff,
  output logic [8*ADDR_BYTES-1:0] addr_q,
  output logic [ALEN_W-1:0]       idx_q,
  input  logic [7:0]              addr_byte,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [7:0]              wr_data,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [7:0]              rd_data,
  output logic                    eng_cmd_valid,
  input  logic                    eng_cmd_ready,
  output logic [1:0]              eng_cmd_op,
  output logic [7:0]              eng_cmd_byte,
  output logic                    eng_cmd_nack,
  input  logic                    eng_done,
  input  logic [7:0]              eng_rx_byte,
  input  logic                    eng_rx_nack,
  output logic                    resp_valid,
  output logic                    resp_err,
  output logic [CNT_W-1:0]        resp_fails
);

  localparam logic [ALEN_W-1:0] ALEN_MAX = ALEN_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  seq_state_e        state_q;
  logic              cmd_valid_q;
  logic              is_read_q, is_write_q, alen_nz_q;
  logic [DEV_W-1:0]  dev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_init_q, fail_q;
  logic [7:0]        wbyte_q, rd_data_q;
  logic              rd_valid_q, err_q;
  logic [ALEN_W-1:0] alen_c;
  logic              fin;
  eng_op_e           cmd_op;

  assign alen_c = (req_alen > ALEN_MAX) ? ALEN_MAX : req_alen;
  assign fin    = eng_done && !cmd_valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cmd_valid_q <= 1'b0;
      is_read_q   <= 1'b0;
      is_write_q  <= 1'b0;
      alen_nz_q   <= 1'b0;
      dev_q       <= '0;
      addr_q      <= '0;
      idx_q       <= '0;
      cnt_q       <= '0;
      cnt_init_q  <= '0;
      fail_q      <= '0;
      wbyte_q     <= '0;
      rd_data_q   <= '0;
      rd_valid_q  <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (cmd_valid_q && eng_cmd_ready) cmd_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          is_read_q   <= req_op[1];
          is_write_q  <= !req_op[1] && req_op[0];
          alen_nz_q   <= (alen_c != '0);
          idx_q       <= alen_c - ALEN_W'(1);
          dev_q       <= dev_eff;
          addr_q      <= req_addr;
          cnt_q       <= req_count;
          cnt_init_q  <= req_count;
          fail_q      <= '0;
          err_q       <= 1'b0;
          state_q     <= ST_START1;
          cmd_valid_q <= 1'b1;
        end
        ST_START1: if (fin) begin
          cmd_valid_q <= 1'b1;
          state_q     <= (is_read_q && !alen_nz_q) ? ST_DEVR : ST_DEVW;
        end
        ST_DEVW: if (fin) begin
          cmd_valid_q <= 1'b1;
          if (eng_rx_nack) begin
            err_q   <= 1'b1;
            state_q <= ST_STOPF;
          end else if (!is_read_q && !is_write_q) begin
            state_q <= ST_STOPF;
          end else if (alen_nz_q) begin
            state_q <= ST_ADDR;
          end else if (cnt_q == '0) begin
            state_q <= ST_STOPF;
          end else begin
            cmd_valid_q <= 1'b0;
            state_q     <= ST_WWAIT;
          end
        end
        ST_ADDR: if (fin) begin
          if (eng_rx_nack) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (idx_q != '0) begin
            idx_q       <= idx_q - ALEN_W'(1);
            cmd_valid_q <= 1'b1;
          end else if (is_read_q) begin
            cmd_valid_q <= 1'b1;
            state_q     <= ST_STOPM;
          end else if (cnt_q == '0) begin
            cmd_valid_q <= 1'b1;
            state_q     <= ST_STOPF;
          end else begin
            state_q <= ST_WWAIT;
          end
        end
        ST_WWAIT: if (wr_valid) begin
          wbyte_q     <= wr_data;
          cmd_valid_q <= 1'b1;
          state_q     <= ST_WDATA;
        end
        ST_WDATA: if (fin) begin
          if (eng_rx_nack) fail_q <= fail_q + CNT_W'(1);
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_ONE) begin
            cmd_valid_q <= 1'b1;
            state_q     <= ST_STOPF;
          end else begin
            state_q <= ST_WWAIT;
          end
        end
        ST_STOPM: if (fin) begin
          cmd_valid_q <= 1'b1;
          state_q     <= ST_START2;
        end
        ST_START2: if (fin) begin
          cmd_valid_q <= 1'b1;
          state_q     <= ST_DEVR;
        end
        ST_DEVR: if (fin) begin
          cmd_valid_q <= 1'b1;
          state_q     <= (cnt_q == '0) ? ST_STOPF : ST_RDATA;
        end
        ST_RDATA: if (fin) begin
          rd_data_q  <= eng_rx_byte;
          rd_valid_q <= 1'b1;
          state_q    <= ST_RPUSH;
        end
        ST_RPUSH: if (rd_ready) begin
          rd_valid_q  <= 1'b0;
          cnt_q       <= cnt_q - CNT_W'(1);
          cmd_valid_q <= 1'b1;
          state_q     <= (cnt_q == CNT_ONE) ? ST_STOPF : ST_RDATA;
        end
        ST_STOPF: if (fin) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // command fields follow the state register
  always_comb begin
    cmd_op       = ENG_START;
    eng_cmd_byte = '0;
    eng_cmd_nack = 1'b0;
    case (state_q)
      ST_STOPM, ST_STOPF: cmd_op = ENG_STOP;
      ST_DEVW: begin cmd_op = ENG_WRITE; eng_cmd_byte = {dev_q, 1'b0}; end
      ST_DEVR: begin cmd_op = ENG_WRITE; eng_cmd_byte = {dev_q, 1'b1}; end
      ST_ADDR: begin cmd_op = ENG_WRITE; eng_cmd_byte = addr_byte; end
      ST_WDATA: begin cmd_op = ENG_WRITE; eng_cmd_byte = wbyte_q; end
      ST_RDATA: begin cmd_op = ENG_READ; eng_cmd_nack = (cnt_q == CNT_ONE); end
      default: cmd_op = ENG_START;
    endcase
  end

  assign eng_cmd_op    = cmd_op;
  assign eng_cmd_valid = cmd_valid_q;
  assign req_ready     = (state_q == ST_IDLE);
  assign wr_ready      = (state_q == ST_WWAIT);
  assign rd_valid      = rd_valid_q;
  assign rd_data       = rd_data_q;
  assign resp_valid    = (state_q == ST_DONE);
  assign resp_err      = err_q;
  assign resp_fails    = fail_q;

  // R12: an offered command holds still until taken
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (eng_cmd_valid && !eng_cmd_ready) |=>
      (eng_cmd_valid && $stable(eng_cmd_op) && $stable(eng_cmd_byte)));

  // R6: an offered read byte holds still until taken
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R7: refused device address leads straight to a STOP
  p_dev_nack_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEVW && fin && eng_rx_nack) |=>
      (eng_cmd_valid && eng_cmd_op == ENG_STOP));

  // R8: refused address byte ends the transaction with no command offered
  p_addr_nack_end_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR && fin && eng_rx_nack) |=>
      (resp_valid && resp_err && !eng_cmd_valid));

  // R9: refusals never exceed the captured byte count
  p_fail_bound_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_fails <= cnt_init_q));

endmodule

// File: rtl/memxfer_seq.sv
module memxfer_seq
  import memxfer_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int ALEN_W     = 3,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [6:0]              req_dev,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  input  logic [ALEN_W-1:0]       req_alen,
  input  logic [CNT_W-1:0]        req_count,
  input  logic                    req_fold_en,
  input  logic [6:0]              req_fold_mask,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [7:0]              wr_data,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [7:0]              rd_data,
  output logic                    eng_cmd_valid,
  input  logic                    eng_cmd_ready,
  output logic [1:0]              eng_cmd_op,
  output logic [7:0]              eng_cmd_byte,
  output logic                    eng_cmd_nack,
  input  logic                    eng_done,
  input  logic [7:0]              eng_rx_byte,
  input  logic                    eng_rx_nack,
  output logic                    resp_valid,
  output logic                    resp_err,
  output logic [CNT_W-1:0]        resp_fails
);

  logic [DEV_W-1:0]        dev_eff;
  logic [8*ADDR_BYTES-1:0] addr_q;
  logic [ALEN_W-1:0]       idx_q;
  logic [7:0]              addr_byte;

  memxfer_devfold #(.ADDR_BYTES(ADDR_BYTES), .ALEN_W(ALEN_W)) u_fold (
    .clk(clk), .rst(rst), .dev(req_dev), .addr(req_addr), .alen(req_alen),
    .en(req_fold_en), .mask(req_fold_mask), .dev_out(dev_eff)
  );

  memxfer_bytesel #(.ADDR_BYTES(ADDR_BYTES), .ALEN_W(ALEN_W)) u_sel (
    .addr(addr_q), .idx(idx_q), .sel(addr_byte)
  );

  memxfer_ctrl #(.ADDR_BYTES(ADDR_BYTES), .ALEN_W(ALEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_alen(req_alen), .req_count(req_count),
    .dev_eff(dev_eff), .addr_q(addr_q), .idx_q(idx_q), .addr_byte(addr_byte),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_cmd_op(eng_cmd_op), .eng_cmd_byte(eng_cmd_byte), .eng_cmd_nack(eng_cmd_nack),
    .eng_done(eng_done), .eng_rx_byte(eng_rx_byte), .eng_rx_nack(eng_rx_nack),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_fails(resp_fails)
  );

endmodule

// File: tb/memxfer_seq_tb.sv
module memxfer_seq_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [1:0]  req_op;
  logic [6:0]  req_dev, req_fold_mask;
  logic [31:0] req_addr;
  logic [2:0]  req_alen;
  logic [15:0] req_count;
  logic        req_fold_en;
  logic        wr_valid, wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid, rd_ready;
  logic [7:0]  rd_data;
  logic        eng_cmd_valid, eng_cmd_ready, eng_cmd_nack;
  logic [1:0]  eng_cmd_op;
  logic [7:0]  eng_cmd_byte;
  logic        eng_done, eng_rx_nack;
  logic [7:0]  eng_rx_byte;
  logic        resp_valid, resp_err;
  logic [15:0] resp_fails;

  always #10 clk = ~clk;

  memxfer_seq u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_dev(req_dev),
    .req_addr(req_addr), .req_alen(req_alen), .req_count(req_count),
    .req_fold_en(req_fold_en), .req_fold_mask(req_fold_mask),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready), .eng_cmd_op(eng_cmd_op),
    .eng_cmd_byte(eng_cmd_byte), .eng_cmd_nack(eng_cmd_nack), .eng_done(eng_done),
    .eng_rx_byte(eng_rx_byte), .eng_rx_nack(eng_rx_nack),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_fails(resp_fails)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [10:0] log_q [64];
  logic [10:0] exp_q [64];
  logic [7:0]  rd_seen [16];
  int log_n, exp_n, rd_n;
  int force_nack_idx = -1;
  int stall = 0;
  int widx = 0;
  int rdi = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv,
                     input string what);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic nk, input logic [7:0] b);
    exp_q[exp_n] = {op, nk, b};
    exp_n++;
  endtask

  task automatic check_log(input string tag);
    chk(tag, log_n, exp_n, "command count");
    for (int i = 0; i < exp_n && i < log_n; i++) chk(tag, log_q[i], exp_q[i], "command entry");
  endtask

  // engine and device model: devices 0x50..0x53 answer, reads return 0xC0 + index
  initial begin
    eng_cmd_ready = 1'b0; eng_done = 1'b0; eng_rx_byte = '0; eng_rx_nack = 1'b0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (eng_cmd_valid) begin
        logic [1:0] op;
        logic [7:0] b;
        logic       nk;
        logic       rsp_nack;
        logic [7:0] rsp_byte;
        op = eng_cmd_op;
        b  = (op == 2'd2) ? eng_cmd_byte : 8'h00;
        nk = (op == 2'd3) ? eng_cmd_nack : 1'b0;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk("R12", {29'd0, eng_cmd_valid, eng_cmd_op}, {29'd0, 1'b1, op}, "held command");
          if (op == 2'd2) chk("R12", eng_cmd_byte, b, "held byte");
        end
        eng_cmd_ready = 1'b1;
        if (log_n < 64) begin log_q[log_n] = {op, nk, b}; log_n++; end
        rsp_nack = 1'b0; rsp_byte = '0;
        case (op)
          2'd0: widx = 0;
          2'd2: begin
            if (widx == 0) rsp_nack = !((b[7:1] & 7'h7C) == 7'h50);
            else           rsp_nack = (widx == force_nack_idx);
            widx++;
          end
          2'd3: begin rsp_byte = 8'hC0 + 8'(rdi); rdi++; end
          default: ;
        endcase
        @(negedge clk);
        eng_cmd_ready = 1'b0;
        @(negedge clk);
        eng_done = 1'b1; eng_rx_nack = rsp_nack; eng_rx_byte = rsp_byte;
      end
    end
  end

  task automatic run_txn(input logic [1:0] op, input logic [6:0] dev, input logic [31:0] addr,
                         input logic [2:0] alen, input logic [15:0] cnt, input logic fold,
                         input logic [6:0] mask, input int n_feed, input int n_sink,
                         output logic err, output logic [15:0] fails);
    log_n = 0; exp_n = 0; rd_n = 0; rdi = 0;
    fork
      begin
        req_op = op; req_dev = dev; req_addr = addr; req_alen = alen; req_count = cnt;
        req_fold_en = fold; req_fold_mask = mask; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        err = resp_err; fails = resp_fails;
        @(negedge clk);
      end
      begin
        for (int i = 0; i < n_feed; i++) begin
          wr_valid = 1'b1; wr_data = 8'h60 + 8'(i);
          while (!wr_ready) @(negedge clk);
          @(negedge clk);
          wr_valid = 1'b0;
          if (i % 2 == 1) @(negedge clk);
        end
      end
      begin
        for (int i = 0; i < n_sink; i++) begin
          while (!rd_valid) @(negedge clk);
          repeat ((i % 2) * 3) @(negedge clk);
          rd_ready = 1'b1;
          rd_seen[rd_n] = rd_data; rd_n++;
          @(negedge clk);
          rd_ready = 1'b0;
        end
      end
    join
  endtask

  task automatic t_reset();
    chk("R12", req_ready, 1'b1, "req_ready after reset");
    chk("R12", eng_cmd_valid, 1'b0, "cmd valid after reset");
    chk("R12", rd_valid, 1'b0, "rd_valid after reset");
    chk("R12", wr_ready, 1'b0, "wr_ready after reset");
    chk("R12", resp_valid, 1'b0, "resp_valid after reset");
  endtask

  task automatic t_probe();
    logic e; logic [15:0] f;
    run_txn(2'd0, 7'h50, 32'h0, 3'd0, 16'd0, 1'b0, 7'h0, 0, 0, e, f);
    push(0, 0, 0); push(2, 0, 8'hA0); push(1, 0, 0);
    check_log("R2"); chk("R2", e, 1'b0, "probe present err");
    run_txn(2'd0, 7'h11, 32'h0, 3'd0, 16'd0, 1'b0, 7'h0, 0, 0, e, f);
    push(0, 0, 0); push(2, 0, 8'h22); push(1, 0, 0);
    check_log("R1"); chk("R2", e, 1'b1, "probe absent err");
  endtask

  task automatic t_write_plain();
    logic e; logic [15:0] f;
    stall = 2;
    run_txn(2'd1, 7'h50, 32'h00AB1234, 3'd2, 16'd3, 1'b0, 7'h7F, 3, 0, e, f);
    stall = 0;
    push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'h12); push(2, 0, 8'h34);
    push(2, 0, 8'h60); push(2, 0, 8'h61); push(2, 0, 8'h62); push(1, 0, 0);
    check_log("R3"); chk("R10", e, 1'b0, "unfolded write err"); chk("R9", f, 16'd0, "no fails");
  endtask

  task automatic t_write_last_nack();
    logic e; logic [15:0] f;
    force_nack_idx = 4;
    run_txn(2'd1, 7'h50, 32'h07, 3'd1, 16'd3, 1'b0, 7'h0, 3, 0, e, f);
    force_nack_idx = -1;
    push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'h07);
    push(2, 0, 8'h60); push(2, 0, 8'h61); push(2, 0, 8'h62); push(1, 0, 0);
    check_log("R9"); chk("R9", e, 1'b0, "err"); chk("R9", f, 16'd1, "fail count");
  endtask

  task automatic t_addr_nack();
    logic e; logic [15:0] f;
    force_nack_idx = 2;
    run_txn(2'd1, 7'h50, 32'h1234, 3'd2, 16'd2, 1'b0, 7'h0, 0, 0, e, f);
    force_nack_idx = -1;
    push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'h12); push(2, 0, 8'h34);
    repeat (8) @(negedge clk);
    check_log("R8"); chk("R8", e, 1'b1, "addr refusal err");
  endtask

  task automatic t_dev_nack();
    logic e; logic [15:0] f;
    run_txn(2'd2, 7'h20, 32'h1, 3'd1, 16'd2, 1'b0, 7'h0, 0, 0, e, f);
    push(0, 0, 0); push(2, 0, 8'h40); push(1, 0, 0);
    check_log("R7"); chk("R7", e, 1'b1, "device refusal err");
  endtask

  task automatic t_read_addr();
    logic e; logic [15:0] f;
    run_txn(2'd2, 7'h50, 32'h05, 3'd1, 16'd3, 1'b0, 7'h0, 0, 3, e, f);
    push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'h05); push(1, 0, 0);
    push(0, 0, 0); push(2, 0, 8'hA1); push(3, 0, 0); push(3, 0, 0); push(3, 1, 0);
    push(1, 0, 0);
    check_log("R4"); chk("R6", e, 1'b0, "read err"); chk("R6", rd_n, 3, "bytes delivered");
    for (int i = 0; i < 3; i++) chk("R6", rd_seen[i], 8'hC0 + 8'(i), "read byte");
  endtask

  task automatic t_read_noaddr();
    logic e; logic [15:0] f;
    run_txn(2'd3, 7'h50, 32'h0, 3'd0, 16'd1, 1'b0, 7'h0, 0, 1, e, f);
    push(0, 0, 0); push(2, 0, 8'hA1); push(3, 1, 0); push(1, 0, 0);
    check_log("R5"); chk("R5", rd_seen[0], 8'hC0, "single byte");
  endtask

  task automatic t_fold();
    logic e; logic [15:0] f;
    run_txn(2'd1, 7'h50, 32'h0F05, 3'd1, 16'd1, 1'b1, 7'h03, 1, 0, e, f);
    push(0, 0, 0); push(2, 0, 8'hA6); push(2, 0, 8'h05); push(2, 0, 8'h60); push(1, 0, 0);
    check_log("R10"); chk("R10", e, 1'b0, "folded write err");
    run_txn(2'd2, 7'h50, 32'h01FF, 3'd1, 16'd1, 1'b1, 7'h01, 0, 1, e, f);
    push(0, 0, 0); push(2, 0, 8'hA2); push(2, 0, 8'hFF); push(1, 0, 0);
    push(0, 0, 0); push(2, 0, 8'hA3); push(3, 1, 0); push(1, 0, 0);
    check_log("R10");
  endtask

  task automatic t_zero_count();
    logic e; logic [15:0] f;
    run_txn(2'd1, 7'h50, 32'h44, 3'd1, 16'd0, 1'b0, 7'h0, 0, 0, e, f);
    push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'h44); push(1, 0, 0);
    check_log("R11"); chk("R11", e, 1'b0, "zero write err");
    run_txn(2'd2, 7'h50, 32'h0, 3'd0, 16'd0, 1'b0, 7'h0, 0, 0, e, f);
    push(0, 0, 0); push(2, 0, 8'hA1); push(1, 0, 0);
    check_log("R11");
  endtask

  task automatic t_alen_clamp();
    logic e; logic [15:0] f;
    run_txn(2'd1, 7'h50, 32'hDEADBEEF, 3'd7, 16'd0, 1'b0, 7'h0, 0, 0, e, f);
    push(0, 0, 0); push(2, 0, 8'hA0); push(2, 0, 8'hDE); push(2, 0, 8'hAD);
    push(2, 0, 8'hBE); push(2, 0, 8'hEF); push(1, 0, 0);
    check_log("R3");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_dev = '0; req_addr = '0; req_alen = '0;
    req_count = '0; req_fold_en = 1'b0; req_fold_mask = '0;
    wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b0;
    log_n = 0; exp_n = 0; rd_n = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_probe();
    t_write_plain();
    t_write_last_nack();
    t_addr_nack();
    t_dev_nack();
    t_read_addr();
    t_read_noaddr();
    t_fold();
    t_zero_count();
    t_alen_clamp();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule